// File: doc/BRIEF.md
# Multi-plane display pixel compositor

This block sits between the pixel fetch logic and the display output of a graphics pipeline. On every pixel clock it takes one 32-bit pixel from each of three stacked planes (bottom, middle, top) and from a cursor overlay. Each pixel carries a flag that says whether the current screen position lies inside that plane's active area. The block removes keyed colors, blends the planes over a programmable background from the bottom upward using each pixel's own 8-bit alpha, and puts the cursor above all three planes. Each color channel then passes through its own 256-entry gamma table.

A 3-bit operating mode selects where the result goes. The block can drive nothing, send the full composite or the bottom plane alone to the panel, send the composite to a memory write-back port, or show a built-in pattern of eight vertical color bars. A mode request is taken up only on a frame-start pulse, so a frame is never split between two modes. Every path has the same fixed latency of four cycles, and the data-enable and sync flags are delayed to match.

Top module: `pixel_compositor`

## Requirements
- R1: Pixels are packed with alpha in [31:24], red in [23:16], green in [15:8] and blue in [7:0]. Valid planes are blended in the order bottom (plane0), middle (plane1), top (plane2). Each step computes `(a*fg + (255-a)*acc + 127)/255` per channel, using integer division.
- R2: When no plane and no cursor is valid, or every valid pixel has alpha 0, the output equals `bg_rgb`.
- R3: When bit p of `key_en` is set, a pixel of plane p is treated as transparent if its red, green and blue each lie within the inclusive range given by `key_lo` and `key_hi` (both packed R[23:16], G[15:8], B[7:0]). When the bit is clear, no keying is applied to that plane.
- R4: A valid cursor pixel is blended last, above all three planes, using its own alpha. The cursor is never keyed.
- R5: Each output channel is mapped through its own 256-entry gamma table. After reset every table is the identity. A write with `gam_we` high stores `gam_data` at `gam_addr` in the table chosen by `gam_sel` (0 red, 1 green, 2 blue). The write applies to pixels entering after that clock edge.
- R6: Mode codes are: 0 no output, 1 composite to panel, 2 bottom plane only to panel, 3 write-back, 4 color bar, and 5 to 7 no output. In mode 2 the middle plane, the top plane and the cursor have no effect. `pan_rgb` is 0 whenever `pan_de` is low.
- R7: In mode 3 the gamma-mapped composite appears on `wb_rgb` with `wb_vld` high. In that mode `pan_de` stays low. `wb_rgb` is 0 whenever `wb_vld` is low, and `pan_de` and `wb_vld` are never high together.
- R8: In mode 4 the output is bar `pix_x*8/H_ACTIVE`, with bars in the order white, yellow, cyan, green, magenta, red, blue, black. A `pix_x` of `H_ACTIVE` or more gives black. The bars bypass the gamma tables.
- R9: `mode_req` is taken up only in a cycle with `frame_start` high. The new mode already applies to the pixel presented in that same cycle. Changes to `mode_req` at other times have no effect.
- R10: A pixel presented before clock edge n appears at the outputs right after edge n+4. `pan_de`/`wb_vld`, `pan_hs` and `pan_vs` are delayed by the same four cycles.
- R11: Reset clears all outputs to 0 and sets the active mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start pulse; takes up mode_req |
| mode_req | input | 3 | Requested operating mode |
| pix_de | input | 1 | Active-pixel flag for the current position |
| hsync_in | input | 1 | Horizontal sync to be delayed |
| vsync_in | input | 1 | Vertical sync to be delayed |
| pix_x | input | XW | Horizontal position within the active line |
| plane0_argb | input | 32 | Bottom plane pixel |
| plane1_argb | input | 32 | Middle plane pixel |
| plane2_argb | input | 32 | Top plane pixel |
| plane_vld | input | 3 | Per-plane inside-active-area flags |
| cursor_argb | input | 32 | Cursor pixel |
| cursor_vld | input | 1 | Cursor covers this position |
| key_en | input | 3 | Per-plane chroma key enable |
| key_lo | input | 24 | Lower key bound per channel |
| key_hi | input | 24 | Upper key bound per channel |
| bg_rgb | input | 24 | Background color |
| gam_we | input | 1 | Gamma table write strobe |
| gam_sel | input | 2 | Gamma table select |
| gam_addr | input | 8 | Gamma table entry |
| gam_data | input | 8 | Gamma table write value |
| pan_rgb | output | 24 | Panel pixel |
| pan_de | output | 1 | Panel data enable |
| pan_hs | output | 1 | Delayed horizontal sync |
| pan_vs | output | 1 | Delayed vertical sync |
| wb_rgb | output | 24 | Write-back pixel |
| wb_vld | output | 1 | Write-back pixel valid |

## Verification
A corrupted latched mode shows up as the wrong route at the ports: data on the write-back port instead of the panel, a blank output, or bars where a composite was expected. It becomes visible four cycles after the first pixel that uses it. A bad gamma entry or a wrong keyed-alpha decision shows up as a wrong color on the very next pixel that uses that entry or plane, also four cycles later. A slip in any pipeline stage misaligns the data-enable and sync flags against the data, and a pulse fed one cycle at a time exposes this at once.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
   localparam int CW  = 8;
   localparam int NPL = 3;

   typedef logic [CW-1:0] comp_t;
   typedef struct packed { comp_t a; comp_t r; comp_t g; comp_t b; } argb_t;
   typedef struct packed { comp_t r; comp_t g; comp_t b; } rgb_t;

   typedef enum logic [2:0] {
      MD_OFF   = 3'd0,
      MD_COMP  = 3'd1,
      MD_BASE  = 3'd2,
      MD_WBACK = 3'd3,
      MD_BAR   = 3'd4
   } mode_e;

   // rounded a*f + (255-a)*b over 255; divide done as shift-add
   function automatic comp_t mix(input comp_t al, input comp_t fg, input comp_t bk);
      logic [16:0] y;
      logic [16:0] q;
      y = 17'(al) * 17'(fg) + (17'd255 - 17'(al)) * 17'(bk) + 17'd127;
      q = (y + 17'd1 + (y >> 8)) >> 8;
      return q[CW-1:0];
   endfunction

   function automatic rgb_t over(input argb_t fg, input rgb_t bk);
      rgb_t o;
      o.r = mix(fg.a, fg.r, bk.r);
      o.g = mix(fg.a, fg.g, bk.g);
      o.b = mix(fg.a, fg.b, bk.b);
      return o;
   endfunction

   // index 0..7: white yellow cyan green magenta red blue black
   function automatic rgb_t bar_color(input logic [2:0] idx);
      rgb_t o;
      o.r = {CW{~idx[1]}};
      o.g = {CW{~idx[2]}};
      o.b = {CW{~idx[0]}};
      return o;
   endfunction
endpackage

// File: rtl/cmp_key_stage.sv
module cmp_key_stage
   import cmp_pkg::*;
#(
   parameter int NP = NPL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  argb_t [NP-1:0]    pix_i,
   input  logic  [NP-1:0]    vld_i,
   input  logic  [NP-1:0]    key_en_i,
   input  rgb_t              klo_i,
   input  rgb_t              khi_i,
   input  argb_t             cur_i,
   input  logic              cur_vld_i,
   input  logic              base_only_i,
   output argb_t [NP-1:0]    pix_o,
   output argb_t             cur_o
);
   logic [NP-1:0] keep;

   for (genvar p = 0; p < NP; p++) begin : g_plane
      logic in_rng;
      assign in_rng = (pix_i[p].r >= klo_i.r) && (pix_i[p].r <= khi_i.r) &&
                      (pix_i[p].g >= klo_i.g) && (pix_i[p].g <= khi_i.g) &&
                      (pix_i[p].b >= klo_i.b) && (pix_i[p].b <= khi_i.b);
      if (p == 0) begin : g_base
         assign keep[p] = vld_i[p] && !(key_en_i[p] && in_rng);
      end else begin : g_upper
         assign keep[p] = vld_i[p] && !(key_en_i[p] && in_rng) && !base_only_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_o <= '0;
         cur_o <= '0;
      end else begin
         for (int p = 0; p < NP; p++) begin
            pix_o[p]   <= pix_i[p];
            pix_o[p].a <= keep[p] ? pix_i[p].a : '0;
         end
         cur_o   <= cur_i;
         cur_o.a <= (cur_vld_i && !base_only_i) ? cur_i.a : '0;
      end
   end
endmodule

// File: rtl/cmp_blend_core.sv
module cmp_blend_core
   import cmp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  argb_t [NPL-1:0]   pix_i,
   input  argb_t             cur_i,
   input  rgb_t              bg_i,
   output rgb_t              mix_o
);
   rgb_t  lo_q;
   argb_t top_q;
   argb_t cur_q;

   // stage A: bottom and middle over background
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         top_q <= '0;
         cur_q <= '0;
      end else begin
         lo_q  <= over(pix_i[1], over(pix_i[0], bg_i));
         top_q <= pix_i[2];
         cur_q <= cur_i;
      end
   end

   // stage B: top plane, then cursor
   always_ff @(posedge clk) begin
      if (!rst_n) mix_o <= '0;
      else        mix_o <= over(cur_q, over(top_q, lo_q));
   end
endmodule

// File: rtl/cmp_gamma_lut.sv
module cmp_gamma_lut
   import cmp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we_i,
   input  logic [1:0]  sel_i,
   input  comp_t       addr_i,
   input  comp_t       data_i,
   input  rgb_t        px_i,
   input  rgb_t        bar_i,
   input  logic        bypass_i,
   output rgb_t        px_o
);
   localparam int DEPTH = 1 << CW;
   localparam int NCH   = 3;

   logic [NCH*CW-1:0] pxv, barv, outv;
   assign pxv  = px_i;
   assign barv = bar_i;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int LO = (NCH - 1 - c) * CW;   // code 0 is red, the top lane
      comp_t tbl [DEPTH];
      comp_t lane_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= CW'(i);
         end else if (we_i && sel_i == 2'(c)) begin
            tbl[addr_i] <= data_i;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)        lane_q <= '0;
         else if (bypass_i) lane_q <= barv[LO +: CW];
         else               lane_q <= tbl[pxv[LO +: CW]];
      end

      assign outv[LO +: CW] = lane_q;
   end

   assign px_o = outv;
endmodule

// File: rtl/pixel_compositor.sv
module pixel_compositor
   import cmp_pkg::*;
#(
   parameter int H_ACTIVE = 64,
   parameter int XW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic [2:0]    mode_req,
   input  logic          pix_de,
   input  logic          hsync_in,
   input  logic          vsync_in,
   input  logic [XW-1:0] pix_x,
   input  logic [31:0]   plane0_argb,
   input  logic [31:0]   plane1_argb,
   input  logic [31:0]   plane2_argb,
   input  logic [2:0]    plane_vld,
   input  logic [31:0]   cursor_argb,
   input  logic          cursor_vld,
   input  logic [2:0]    key_en,
   input  logic [23:0]   key_lo,
   input  logic [23:0]   key_hi,
   input  logic [23:0]   bg_rgb,
   input  logic          gam_we,
   input  logic [1:0]    gam_sel,
   input  logic [7:0]    gam_addr,
   input  logic [7:0]    gam_data,
   output logic [23:0]   pan_rgb,
   output logic          pan_de,
   output logic          pan_hs,
   output logic          pan_vs,
   output logic [23:0]   wb_rgb,
   output logic          wb_vld
);
   localparam int LAT  = 4;
   localparam int BARS = 8;
   localparam int SW   = XW + 3;

   if (H_ACTIVE < BARS) begin : g_chk_w
      $error("H_ACTIVE must hold at least one pixel per bar");
   end
   if (H_ACTIVE >= (1 << XW)) begin : g_chk_x
      $error("XW too narrow for H_ACTIVE");
   end

   typedef struct packed {
      logic       de;
      logic       hs;
      logic       vs;
      logic [2:0] md;
   } ctl_t;

   logic [2:0] mode_act, mode_now;
   assign mode_now = frame_start ? mode_req : mode_act;

   always_ff @(posedge clk) begin
      if (!rst_n)           mode_act <= MD_OFF;
      else if (frame_start) mode_act <= mode_req;
   end

   // color bar for the current position
   logic [SW-1:0] scaled;
   logic [2:0]    bar_idx;
   rgb_t          bar_now;
   assign scaled  = {pix_x, 3'b000};
   assign bar_idx = (pix_x >= XW'(H_ACTIVE)) ? 3'd7 : 3'(scaled / SW'(H_ACTIVE));
   assign bar_now = bar_color(bar_idx);

   ctl_t ctl_q [1:LAT];
   rgb_t bar_q [1:LAT-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 1; k <= LAT; k++)   ctl_q[k] <= '0;
         for (int k = 1; k <= LAT-1; k++) bar_q[k] <= '0;
      end else begin
         ctl_q[1] <= '{de: pix_de, hs: hsync_in, vs: vsync_in, md: mode_now};
         for (int k = 2; k <= LAT; k++)   ctl_q[k] <= ctl_q[k-1];
         bar_q[1] <= bar_now;
         for (int k = 2; k <= LAT-1; k++) bar_q[k] <= bar_q[k-1];
      end
   end

   argb_t [NPL-1:0] pl_in, pl_s1;
   argb_t           cur_s1;
   rgb_t            mix_s3, gam_s4;

   assign pl_in[0] = plane0_argb;
   assign pl_in[1] = plane1_argb;
   assign pl_in[2] = plane2_argb;

   cmp_key_stage #(.NP(NPL)) u_key (
      .clk         (clk),
      .rst_n       (rst_n),
      .pix_i       (pl_in),
      .vld_i       (plane_vld),
      .key_en_i    (key_en),
      .klo_i       (key_lo),
      .khi_i       (key_hi),
      .cur_i       (cursor_argb),
      .cur_vld_i   (cursor_vld),
      .base_only_i (mode_now == MD_BASE),
      .pix_o       (pl_s1),
      .cur_o       (cur_s1)
   );

   cmp_blend_core u_blend (
      .clk   (clk),
      .rst_n (rst_n),
      .pix_i (pl_s1),
      .cur_i (cur_s1),
      .bg_i  (bg_rgb),
      .mix_o (mix_s3)
   );

   cmp_gamma_lut u_gamma (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (gam_we),
      .sel_i    (gam_sel),
      .addr_i   (gam_addr),
      .data_i   (gam_data),
      .px_i     (mix_s3),
      .bar_i    (bar_q[LAT-1]),
      .bypass_i (ctl_q[LAT-1].md == MD_BAR),
      .px_o     (gam_s4)
   );

   logic to_pan, to_wb;
   assign to_pan = (ctl_q[LAT].md == MD_COMP) || (ctl_q[LAT].md == MD_BASE) ||
                   (ctl_q[LAT].md == MD_BAR);
   assign to_wb  = (ctl_q[LAT].md == MD_WBACK);

   assign pan_de  = ctl_q[LAT].de && to_pan;
   assign wb_vld  = ctl_q[LAT].de && to_wb;
   assign pan_rgb = pan_de ? gam_s4 : '0;
   assign wb_rgb  = wb_vld ? gam_s4 : '0;
   assign pan_hs  = ctl_q[LAT].hs;
   assign pan_vs  = ctl_q[LAT].vs;
endmodule

// File: rtl/cmp_checker.sv
module cmp_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        pix_de,
   input logic        hsync_in,
   input logic        vsync_in,
   input logic [23:0] pan_rgb,
   input logic        pan_de,
   input logic        pan_hs,
   input logic        pan_vs,
   input logic [23:0] wb_rgb,
   input logic        wb_vld
);
   logic [2:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)        age <= '0;
      else if (age != 7) age <= age + 3'd1;
   end

   // R10
   de_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'd4 && (pan_de || wb_vld)) |-> $past(pix_de, 4));

   // R10
   sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'd4) |-> (pan_hs == $past(hsync_in, 4) && pan_vs == $past(vsync_in, 4)));

   // R7
   route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pan_de && wb_vld));

   // R6
   pan_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pan_de |-> (pan_rgb == 24'h0));

   // R7
   wb_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_vld |-> (wb_rgb == 24'h0));
endmodule

bind pixel_compositor cmp_checker u_chk (.*);

// File: tb/tb_pixel_compositor.sv
module tb_pixel_compositor;
   localparam int H_ACTIVE = 64;
   localparam int XW       = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic [2:0]    mode_req = 3'd0;
   logic          pix_de = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
   logic [XW-1:0] pix_x = '0;
   logic [31:0]   plane0_argb = '0, plane1_argb = '0, plane2_argb = '0, cursor_argb = '0;
   logic [2:0]    plane_vld = '0, key_en = '0;
   logic          cursor_vld = 1'b0;
   logic [23:0]   key_lo = '0, key_hi = '0, bg_rgb = 24'h102030;
   logic          gam_we = 1'b0;
   logic [1:0]    gam_sel = '0;
   logic [7:0]    gam_addr = '0, gam_data = '0;
   logic [23:0]   pan_rgb, wb_rgb;
   logic          pan_de, pan_hs, pan_vs, wb_vld;

   always #4 clk = ~clk;   // 125 MHz

   pixel_compositor #(.H_ACTIVE(H_ACTIVE), .XW(XW)) dut (.*);

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] bl(input logic [31:0] fg, input logic [23:0] bk);
      logic [23:0] o;
      int a;
      a = int'(fg[31:24]);
      for (int c = 0; c < 3; c++) begin
         int f, b;
         f = int'(fg[c*8 +: 8]);
         b = int'(bk[c*8 +: 8]);
         o[c*8 +: 8] = 8'((a * f + (255 - a) * b + 127) / 255);
      end
      return o;
   endfunction

   typedef struct packed {
      logic [2:0]  md;
      logic [2:0]  vld;
      logic [31:0] p0;
      logic [31:0] p1;
      logic [31:0] p2;
      logic        cv;
      logic [31:0] cu;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VT [NV] = '{
      '{3'd1, 3'b000, 32'hFF112233, 32'hFF445566, 32'hFF778899, 1'b0, 32'hFFABCDEF},
      '{3'd1, 3'b001, 32'hFF112233, 32'h00000000, 32'h00000000, 1'b0, 32'h0},
      '{3'd1, 3'b011, 32'hFF112233, 32'h80FFFFFF, 32'h00000000, 1'b0, 32'h0},
      '{3'd1, 3'b111, 32'hFF112233, 32'h80FFFFFF, 32'h4000FF00, 1'b0, 32'h0},
      '{3'd1, 3'b111, 32'hFF112233, 32'h80FFFFFF, 32'h4000FF00, 1'b1, 32'hFFABCDEF},
      '{3'd2, 3'b111, 32'hFF445566, 32'hFF000000, 32'hFFFFFFFF, 1'b1, 32'hFFABCDEF},
      '{3'd2, 3'b011, 32'h80FF00FF, 32'hFF000000, 32'h0,        1'b1, 32'h80FFFFFF},
      '{3'd1, 3'b001, 32'h00FFFFFF, 32'h0,        32'h0,        1'b0, 32'h0}
   };

   function automatic logic [23:0] model(input vec_t v);
      logic [23:0] acc;
      acc = bg_rgb;
      if (v.md == 3'd2) begin
         if (v.vld[0]) acc = bl(v.p0, acc);
      end else begin
         if (v.vld[0]) acc = bl(v.p0, acc);
         if (v.vld[1]) acc = bl(v.p1, acc);
         if (v.vld[2]) acc = bl(v.p2, acc);
         if (v.cv)     acc = bl(v.cu, acc);
      end
      return acc;
   endfunction

   // frame-start pulse with new mode, then hold and sample after the 4th edge
   task automatic frame_pixel(input logic [2:0] md, input logic fs);
      @(negedge clk);
      mode_req = md;
      frame_start = fs;
      @(posedge clk);
      @(negedge clk);
      frame_start = 1'b0;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic gam_write(input logic [1:0] sel, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      gam_we = 1'b1; gam_sel = sel; gam_addr = a; gam_data = d;
      @(negedge clk);
      gam_we = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11
      chk("R11 reset pan_rgb", 32'(pan_rgb), 32'h0);
      chk("R11 reset pan_de", 32'(pan_de), 32'h0);
      chk("R11 reset wb_vld", 32'(wb_vld), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      pix_de = 1'b1;
      // R11 active mode is 0 after reset
      frame_pixel(3'd1, 1'b0);
      chk("R11 mode0 after reset", 32'(pan_de), 32'h0);

      // table walk: R1 R2 R4 R6
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         plane_vld = VT[i].vld;
         plane0_argb = VT[i].p0; plane1_argb = VT[i].p1; plane2_argb = VT[i].p2;
         cursor_vld = VT[i].cv; cursor_argb = VT[i].cu;
         frame_pixel(VT[i].md, 1'b1);
         chk($sformatf("R1 R2 R4 R6 row %0d", i), 32'(pan_rgb), 32'(model(VT[i])));
         chk($sformatf("R6 row %0d de", i), 32'(pan_de), 32'h1);
      end

      // R3 chroma key
      @(negedge clk);
      plane_vld = 3'b011; cursor_vld = 1'b0;
      plane0_argb = 32'hFF112233; plane1_argb = 32'hFF101010;
      key_lo = 24'h000000; key_hi = 24'h101010; key_en = 3'b010;
      frame_pixel(3'd1, 1'b1);
      chk("R3 keyed at inclusive bound", 32'(pan_rgb), 32'h112233);
      @(negedge clk);
      plane1_argb = 32'hFF111010;
      frame_pixel(3'd1, 1'b0);
      chk("R3 outside range shown", 32'(pan_rgb), 32'h111010);
      @(negedge clk);
      plane1_argb = 32'hFF101010; key_en = 3'b000;
      frame_pixel(3'd1, 1'b0);
      chk("R3 key disabled", 32'(pan_rgb), 32'h101010);

      // R9 mode change without frame_start ignored
      @(negedge clk);
      plane_vld = 3'b001; plane0_argb = 32'hFF123456;
      frame_pixel(3'd0, 1'b0);
      chk("R9 no frame_start keeps mode", 32'(pan_rgb), 32'h123456);
      frame_pixel(3'd0, 1'b1);
      chk("R6 R9 mode0 pan_de", 32'(pan_de), 32'h0);
      chk("R6 mode0 wb_vld", 32'(wb_vld), 32'h0);

      // R7 write-back
      frame_pixel(3'd3, 1'b1);
      chk("R7 wb_rgb", 32'(wb_rgb), 32'h123456);
      chk("R7 wb_vld", 32'(wb_vld), 32'h1);
      chk("R7 pan_de low", 32'(pan_de), 32'h0);

      // R5 gamma on red
      gam_write(2'd0, 8'hFF, 8'h10);
      @(negedge clk);
      plane0_argb = 32'hFFFF0000;
      frame_pixel(3'd1, 1'b1);
      chk("R5 red gamma entry", 32'(pan_rgb), 32'h100000);
      gam_write(2'd2, 8'h00, 8'h77);
      frame_pixel(3'd1, 1'b0);
      chk("R5 blue table separate", 32'(pan_rgb), 32'h100077);

      // R8 color bar, bypasses the modified tables
      @(negedge clk); pix_x = 8'd0;
      frame_pixel(3'd4, 1'b1);
      chk("R8 bar0 white", 32'(pan_rgb), 32'hFFFFFF);
      @(negedge clk); pix_x = 8'd8;
      frame_pixel(3'd4, 1'b0);
      chk("R8 bar1 yellow", 32'(pan_rgb), 32'hFFFF00);
      @(negedge clk); pix_x = 8'd23;
      frame_pixel(3'd4, 1'b0);
      chk("R8 bar2 cyan", 32'(pan_rgb), 32'h00FFFF);
      @(negedge clk); pix_x = 8'd40;
      frame_pixel(3'd4, 1'b0);
      chk("R8 bar5 red", 32'(pan_rgb), 32'hFF0000);
      @(negedge clk); pix_x = 8'd70;
      frame_pixel(3'd4, 1'b0);
      chk("R8 beyond line black", 32'(pan_rgb), 32'h000000);
      chk("R8 de", 32'(pan_de), 32'h1);

      gam_write(2'd0, 8'hFF, 8'hFF);
      gam_write(2'd2, 8'h00, 8'h00);

      // R6 reserved mode
      frame_pixel(3'd5, 1'b1);
      chk("R6 mode5 pan_de", 32'(pan_de), 32'h0);
      chk("R6 mode5 wb_vld", 32'(wb_vld), 32'h0);

      // R10 latency with single-cycle pulses
      frame_pixel(3'd1, 1'b1);
      @(negedge clk);
      pix_de = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0;
      repeat (5) @(negedge clk);
      pix_de = 1'b1; hsync_in = 1'b1; vsync_in = 1'b1;
      @(negedge clk);
      pix_de = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0;
      // one edge has passed since the pulse was sampled
      repeat (2) @(posedge clk);
      #1;
      chk("R10 not yet at 3", 32'({pan_de, pan_hs, pan_vs}), 32'h0);
      @(posedge clk);
      #1;
      chk("R10 out at 4", 32'({pan_de, pan_hs, pan_vs}), 32'h7);
      @(posedge clk);
      #1;
      chk("R10 gone at 5", 32'({pan_de, pan_hs, pan_vs}), 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule